// File: doc/BRIEF.md
# Subaddressed Write-Only I2C Register Interface for a Tuning Synthesizer

This block is a write-only I2C target that loads the control words of a radio frequency synthesizer. A bus controller sends a module address byte, then a subaddress byte, then data bytes. One bit of the module address is not fixed. It must equal the level on an address-select input, so two of these blocks can share one bus. The subaddress selects one of two fixed byte sequences. The first is the status byte followed by the two bytes of the reference divider. The second is the two bytes of the main divider.

Bytes are collected in shadow storage. They reach the parallel outputs only when a STOP condition arrives, so the synthesizer never sees a divider with one byte updated and the other stale. A repeated START drops whatever the interrupted transfer had collected. SCL and SDA are sampled through synchronisers on a system clock that runs at least 20 times faster than SCL. The block acknowledges by pulling SDA low through an open-drain enable.

Top module: `i2cTunerIf`

## Requirements
- R1: After reset, `statusByte`, `rDivider` and `nDivider` are all zero and `sdaPullLow` is 0.
- R2: The address byte is {DEV_ADDR[6:2], A1, DEV_ADDR[0], RW}, with RW in bit 0. It is acknowledged only when bit 2 (A1) equals `addrSel` and the other bits match. When the address does not match, the block gives no acknowledge for the rest of that transfer and no output changes at the following STOP.
- R3: An address byte with bit 0 = 1 (a read request) is not acknowledged, and no output changes.
- R4: Subaddress 0x10 (SUB_RDIV) directs the following data bytes, in order, to the status byte, then the high byte of `rDivider`, then the low byte of `rDivider`.
- R5: Subaddress 0x20 (SUB_NDIV) directs the following data bytes, in order, to the high byte of `nDivider`, then its low byte.
- R6: Any other subaddress is not acknowledged. The data bytes after it are not acknowledged, and no output changes.
- R7: A data byte beyond the end of the selected sequence is not acknowledged and changes no output.
- R8: Outputs keep their old values while a transfer is in progress. They take the received bytes only after the STOP condition.
- R9: A repeated START discards bytes received since the previous START. The bytes of the new transfer are committed at its STOP.
- R10: A transfer that ends its sequence early commits only the bytes it delivered. All other bytes keep their values.
- R11: The acknowledge (`sdaPullLow` = 1) is asserted while SCL is low after the eighth bit of an accepted byte, held through the ninth clock, and released while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | I2C clock line |
| sdaIn | input | 1 | I2C data line as seen on the bus |
| addrSel | input | 1 | Level that address bit A1 must match |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low to acknowledge |
| statusByte | output | 8 | Committed status and switching-output byte |
| rDivider | output | 16 | Committed reference divider value |
| nDivider | output | 16 | Committed main divider value |

## Verification
The table-driven transfers cover the following cases:
- A full reference sequence.
- A full main sequence.
- A main sequence with a third byte that overruns it.
- A one-byte partial reference write.
- An unknown subaddress.
- A match with address-select high.
- An address-select mismatch.
- A read request.

Each case checks the acknowledge pattern byte by byte, which separates sequence-end handling from address and subaddress decoding. The committed outputs show which byte went to which register and that untouched bytes keep their values. Directed tests read the outputs before and after STOP to show that updates are deferred. They also break a transfer with a repeated START to show that the interrupted bytes never appear.

// File: rtl/tunerIfPkg.sv
package tunerIfPkg;
  localparam int NUM_DB   = 5;
  localparam int DB_IDX_W = $clog2(NUM_DB + 1);
  localparam int SEQ_R_START = 0;
  localparam int SEQ_R_END   = 3;
  localparam int SEQ_N_START = 3;
  localparam int SEQ_N_END   = NUM_DB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP
  } busState_e;

  typedef struct packed {
    logic                load;
    logic [DB_IDX_W-1:0] idx;
    logic [7:0]          data;
    logic                commit;
    logic                discard;
  } regStrobe_t;
endpackage

// File: rtl/tunerBusCtrl.sv
module tunerBusCtrl
  import tunerIfPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h62,
  parameter logic [7:0] SUB_RDIV    = 8'h10,
  parameter logic [7:0] SUB_NDIV    = 8'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaPullLow,
  output regStrobe_t strobe,
  output logic       ignoring
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic startCond, stopCond, sclRise, sclFall, addrHit;
  busState_e state;
  logic [3:0] bitCnt;
  logic inAck;
  logic [7:0] shiftReg;
  logic [DB_IDX_W-1:0] ptr, endPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], scl};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign startCond = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopCond  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise   = sclS && !sclPrev;
  assign sclFall   = !sclS && sclPrev;
  assign addrHit   = (shiftReg[7:3] == DEV_ADDR[6:2]) && (shiftReg[2] == addrSel)
                     && (shiftReg[1] == DEV_ADDR[0]) && !shiftReg[0];
  assign ignoring  = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      shiftReg   <= '0;
      ptr        <= '0;
      endPtr     <= '0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe <= '0;
      if (startCond) begin
        state          <= ST_ADDR;
        bitCnt         <= '0;
        inAck          <= 1'b0;
        sdaPullLow     <= 1'b0;
        strobe.discard <= 1'b1;
      end else if (stopCond) begin
        if (state != ST_IDLE) strobe.commit <= 1'b1;
        state      <= ST_IDLE;
        inAck      <= 1'b0;
        sdaPullLow <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise && !inAck && bitCnt != 4'd8) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 4'd1;
        end else if (sclFall && inAck) begin
          inAck      <= 1'b0;
          sdaPullLow <= 1'b0;
          bitCnt     <= '0;
        end else if (sclFall && bitCnt == 4'd8) begin
          inAck <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (addrHit) begin
                sdaPullLow <= 1'b1;
                state      <= ST_SUB;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_SUB: begin
              if (shiftReg == SUB_RDIV) begin
                ptr        <= DB_IDX_W'(SEQ_R_START);
                endPtr     <= DB_IDX_W'(SEQ_R_END);
                sdaPullLow <= 1'b1;
                state      <= ST_DATA;
              end else if (shiftReg == SUB_NDIV) begin
                ptr        <= DB_IDX_W'(SEQ_N_START);
                endPtr     <= DB_IDX_W'(SEQ_N_END);
                sdaPullLow <= 1'b1;
                state      <= ST_DATA;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_DATA: begin
              if (ptr != endPtr) begin
                strobe.load <= 1'b1;
                strobe.idx  <= ptr;
                strobe.data <= shiftReg;
                ptr         <= ptr + 1'b1;
                sdaPullLow  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tunerRegPath.sv
module tunerRegPath
  import tunerIfPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  regStrobe_t                  strobe,
  output logic [NUM_DB-1:0][7:0]      dbOut
);
  for (genvar g = 0; g < NUM_DB; g++) begin : g_byte
    logic [7:0] shadow;
    logic       pending;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow   <= '0;
        pending  <= 1'b0;
        dbOut[g] <= '0;
      end else if (strobe.discard) begin
        pending <= 1'b0;
      end else if (strobe.commit) begin
        if (pending) dbOut[g] <= shadow;
        pending <= 1'b0;
      end else if (strobe.load && strobe.idx == DB_IDX_W'(g)) begin
        shadow  <= strobe.data;
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cTunerIf.sv
module i2cTunerIf
  import tunerIfPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h62,
  parameter logic [7:0] SUB_RDIV = 8'h10,
  parameter logic [7:0] SUB_NDIV = 8'h20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scl,
  input  logic        sdaIn,
  input  logic        addrSel,
  output logic        sdaPullLow,
  output logic [7:0]  statusByte,
  output logic [15:0] rDivider,
  output logic [15:0] nDivider
);
  regStrobe_t strobe;
  logic ignoring;
  logic [NUM_DB-1:0][7:0] dbOut;

  tunerBusCtrl #(
    .DEV_ADDR(DEV_ADDR), .SUB_RDIV(SUB_RDIV), .SUB_NDIV(SUB_NDIV), .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .strobe(strobe), .ignoring(ignoring)
  );

  tunerRegPath u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dbOut(dbOut)
  );

  assign statusByte = dbOut[0];
  assign rDivider   = {dbOut[1], dbOut[2]};
  assign nDivider   = {dbOut[3], dbOut[4]};
endmodule

// File: rtl/tunerIfChecker.sv
module tunerIfChecker
  import tunerIfPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        scl,
  input logic        sdaPullLow,
  input logic [7:0]  statusByte,
  input logic [15:0] rDivider,
  input logic [15:0] nDivider,
  input regStrobe_t  strobe,
  input logic        ignoring
);
  // R8: outputs move only right after a commit strobe
  p_hold_until_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(statusByte) || !$stable(rDivider) || !$stable(nDivider)) |-> $past(strobe.commit));

  // R2: no acknowledge while the transfer is being ignored
  p_no_ack_skip_r2: assert property (@(posedge clk) disable iff (!rstN)
    ignoring |-> !sdaPullLow);

  // R11: acknowledge starts while SCL is low
  p_ack_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !scl);

  // R11: acknowledge ends while SCL is low
  p_ack_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !scl);

  // R9: load, commit and discard never coincide
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.commit, strobe.discard}));
endmodule

bind i2cTunerIf tunerIfChecker u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaPullLow(sdaPullLow),
  .statusByte(statusByte), .rDivider(rDivider), .nDivider(nDivider),
  .strobe(strobe), .ignoring(ignoring)
);

// File: tb/sim_i2cTunerIf.sv
module sim_i2cTunerIf;
  localparam int HP = 25;

  typedef struct packed {
    logic        sel;
    logic [7:0]  addr;
    logic [7:0]  sub;
    logic [1:0]  nData;
    logic [7:0]  d0, d1, d2;
    logic [4:0]  ackExp;
    logic [7:0]  st;
    logic [15:0] rd, nd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hC0, 8'h10, 2'd3, 8'hA5, 8'h12, 8'h34, 5'b11111, 8'hA5, 16'h1234, 16'h0000}, // R4
    '{1'b0, 8'hC0, 8'h20, 2'd2, 8'h56, 8'h78, 8'h00, 5'b11110, 8'hA5, 16'h1234, 16'h5678}, // R5
    '{1'b0, 8'hC0, 8'h20, 2'd3, 8'h9A, 8'hBC, 8'hDE, 5'b11110, 8'hA5, 16'h1234, 16'h9ABC}, // R7
    '{1'b0, 8'hC0, 8'h10, 2'd1, 8'h3C, 8'h00, 8'h00, 5'b11100, 8'h3C, 16'h1234, 16'h9ABC}, // R10
    '{1'b0, 8'hC0, 8'h33, 2'd1, 8'hFF, 8'h00, 8'h00, 5'b10000, 8'h3C, 16'h1234, 16'h9ABC}, // R6
    '{1'b0, 8'hC0, 8'h10, 2'd3, 8'h00, 8'hFF, 8'h01, 5'b11111, 8'h00, 16'hFF01, 16'h9ABC}, // R4
    '{1'b1, 8'hC4, 8'h20, 2'd2, 8'h78, 8'h9A, 8'h00, 5'b11110, 8'h00, 16'hFF01, 16'h789A}, // R2
    '{1'b1, 8'hC0, 8'h10, 2'd3, 8'h11, 8'h22, 8'h33, 5'b00000, 8'h00, 16'hFF01, 16'h789A}, // R2
    '{1'b0, 8'hC1, 8'h10, 2'd1, 8'h77, 8'h00, 8'h00, 5'b00000, 8'h00, 16'hFF01, 16'h789A}  // R3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaPullLow;
  logic [7:0] statusByte;
  logic [15:0] rDivider, nDivider;
  logic sdaLine;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #5 clk = ~clk;

  i2cTunerIf u0 (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .statusByte(statusByte), .rDivider(rDivider), .nDivider(nDivider)
  );

  function automatic string vecReq(int i);
    case (i)
      0, 5: return "R4";
      1: return "R5";
      2: return "R7";
      3: return "R10";
      4: return "R6";
      6, 7: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(HP/2);
    scl = 1'b1;  waitClk(HP);
    sdaM = 1'b0; waitClk(HP);
    scl = 1'b0;  waitClk(HP/2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(HP/2);
    scl = 1'b1;  waitClk(HP);
    sdaM = 1'b1; waitClk(HP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(HP/2);
      scl = 1'b1;  waitClk(HP);
      scl = 1'b0;  waitClk(HP/2);
    end
    sdaM = 1'b1; waitClk(HP/2);
    scl = 1'b1;  waitClk(HP/2);
    ack = !sdaLine;
    waitClk(HP/2);
    scl = 1'b0;  waitClk(HP/2);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    logic a;
    logic [4:0] got, mask;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R1: reset state
    check(statusByte == 8'h00 && rDivider == 16'h0 && nDivider == 16'h0 && !sdaPullLow, "R1",
          {statusByte, rDivider, nDivider, 7'd0, sdaPullLow}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      addrSel = VECS[v].sel;
      waitClk(4);
      got = '0;
      busStart();
      sendByte(VECS[v].addr, a); got[4] = a;
      sendByte(VECS[v].sub, a);  got[3] = a;
      if (VECS[v].nData >= 2'd1) begin sendByte(VECS[v].d0, a); got[2] = a; end
      if (VECS[v].nData >= 2'd2) begin sendByte(VECS[v].d1, a); got[1] = a; end
      if (VECS[v].nData >= 2'd3) begin sendByte(VECS[v].d2, a); got[0] = a; end
      busStop();
      waitClk(8);
      mask = {2'b11, VECS[v].nData >= 2'd1, VECS[v].nData >= 2'd2, VECS[v].nData >= 2'd3};
      // R11: acknowledge pattern per byte
      check((got & mask) == (VECS[v].ackExp & mask), {vecReq(v), "/R11 ack"},
            64'(got & mask), 64'(VECS[v].ackExp & mask));
      check(statusByte == VECS[v].st && rDivider == VECS[v].rd && nDivider == VECS[v].nd,
            {vecReq(v), " regs"}, {24'd0, statusByte, rDivider, nDivider},
            {24'd0, VECS[v].st, VECS[v].rd, VECS[v].nd});
    end

    // R8: nothing visible before STOP
    addrSel = 1'b0;
    busStart();
    sendByte(8'hC0, a);
    sendByte(8'h20, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    waitClk(8);
    check(nDivider == 16'h789A, "R8 before stop", 64'(nDivider), 64'h789A);
    busStop();
    waitClk(8);
    check(nDivider == 16'h1122, "R8 after stop", 64'(nDivider), 64'h1122);

    // R9: repeated START discards the interrupted bytes
    busStart();
    sendByte(8'hC0, a);
    sendByte(8'h10, a);
    sendByte(8'h44, a);
    sendByte(8'h55, a);
    sendByte(8'h66, a);
    busStart();
    sendByte(8'hC0, a);
    sendByte(8'h20, a);
    sendByte(8'hAB, a);
    sendByte(8'hCD, a);
    busStop();
    waitClk(8);
    check(statusByte == 8'h00 && rDivider == 16'hFF01, "R9 dropped", {statusByte, rDivider},
          {8'h00, 16'hFF01});
    check(nDivider == 16'hABCD, "R9 new", 64'(nDivider), 64'hABCD);
    check(!sdaPullLow, "R11 released", 64'(sdaPullLow), 64'h0);

    done = 1;
    summary();
  end
endmodule